// File: doc/BRIEF.md
# Peripheral Flow-Control DMA Request Generator

This block lives inside a peripheral that owns the length of each packet it moves through a DMA controller. Software or neighbouring logic loads a packet length and a burst size; the block then watches how many data items the peripheral has ready and raises exactly one of four request lines toward the controller: burst, last burst, single or last single. The choice depends on how many items remain in the packet. A raised request is held until the controller returns a one-cycle clear, after which the remaining count drops by the amount just serviced and the choice is made again.

The controller does not know the packet length. It learns the end of the packet only from the two "last" request kinds. Once a last request has been cleared, the generator pulses a packet-complete output and stays quiet until a new length is loaded.

The control is a six-state machine. `ST_IDLE` waits for a load. `ST_EVAL` picks a request kind from the remaining count, the burst size and the ready count, and stays there while nothing qualifies. `ST_BURST`, `ST_LBURST`, `ST_SINGLE` and `ST_LSINGLE` each drive their own request line until the clear arrives. Its transitions are:

- load with a nonzero length: IDLE to EVAL;
- a qualifying kind: EVAL to the matching request state;
- clear in BURST or SINGLE: back to EVAL;
- clear in LBURST or LSINGLE: back to IDLE.

Top module: `dreq_flowgen`

## Requirements
- R1: At most one of `req_burst`, `req_last_burst`, `req_single`, `req_last_single` is high in any cycle.
- R2: When the remaining count is greater than the burst size and `ready_cnt` is at least the burst size, `req_burst` is raised.
- R3: When the remaining count equals the burst size, the burst size is 2 or more, and `ready_cnt` is at least the burst size, `req_last_burst` is raised instead of `req_burst`.
- R4: When the remaining count is below the burst size and `ready_cnt` is at least 1, a single item is requested. `req_last_single` is used when the remaining count is 1, and `req_single` otherwise. With a burst size of 1, the final item also uses `req_last_single`.
- R5: A raised request stays high, unchanged, until `dma_clr` is sampled high. A pending single request is not replaced by a burst request when `ready_cnt` grows.
- R6: A clear on a burst-kind request lowers the remaining count by the burst size; a clear on a single-kind request lowers it by 1. In the cycle after the clear all requests are low, and the choice is made again from the new count.
- R7: `pkt_done` is a one-cycle pulse in the cycle after a last request is cleared. No request follows until the next load.
- R8: Loading a length of 0 yields no requests and no `pkt_done`. Loading a length of 1 yields only `req_last_single`.
- R9: `load` is accepted only when no packet is in progress and is ignored otherwise. A burst size of 0 is taken as 1.
- R10: After reset all four requests and `pkt_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Start a packet with `pkt_len` and `burst_sz` |
| pkt_len | input | LEN_W | Number of items in the packet |
| burst_sz | input | BURST_W | Items per burst (0 taken as 1) |
| ready_cnt | input | LEN_W | Items the peripheral has ready now |
| dma_clr | input | 1 | One-cycle service pulse from the DMA controller |
| req_burst | output | 1 | Burst request |
| req_last_burst | output | 1 | Final burst request of the packet |
| req_single | output | 1 | Single-item request |
| req_last_single | output | 1 | Final single-item request of the packet |
| pkt_done | output | 1 | Pulses after the last request is cleared |

## Verification
The bound checker watches four properties on every cycle:

- the request lines are one-hot or all low;
- a request is held stable until cleared, which also covers the rule against promoting a single to a burst;
- there is an empty cycle after each clear;
- `pkt_done` is a single pulse that follows only the clear of a last request and coincides with no request.

Which kind is chosen for a given remaining count, burst size and ready level, and the arithmetic of the remaining count across a whole packet, can be shown only by the bench. Its scenarios track the expected count per packet: zero and one-item lengths, exact multiples of the burst, odd remainders, a zero burst size and a load during a busy packet.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_BURST,
        ST_LBURST,
        ST_SINGLE,
        ST_LSINGLE
    } dreq_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_BURST,
        K_LBURST,
        K_SINGLE,
        K_LSINGLE
    } dreq_kind_e;

endpackage

// File: rtl/dreq_select.sv
module dreq_select
    import dreq_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int BURST_W = 5
) (
    input  logic [LEN_W-1:0]   rem,
    input  logic [BURST_W-1:0] bsz,
    input  logic [LEN_W-1:0]   ready,
    output dreq_kind_e         kind
);

    logic [LEN_W-1:0] bsz_ext;
    logic             burst_ok;
    logic             item_ok;

    assign bsz_ext  = LEN_W'(bsz);
    assign burst_ok = (ready >= bsz_ext);
    assign item_ok  = (ready != '0);

    always_comb begin
        kind = K_NONE;
        if (rem == '0) begin
            kind = K_NONE;
        end else if (rem == LEN_W'(1)) begin
            kind = item_ok ? K_LSINGLE : K_NONE;
        end else if (rem < bsz_ext) begin
            kind = item_ok ? K_SINGLE : K_NONE;
        end else if (rem == bsz_ext) begin
            kind = burst_ok ? K_LBURST : K_NONE;
        end else begin
            kind = burst_ok ? K_BURST : K_NONE;
        end
    end

endmodule

// File: rtl/dreq_count.sv
module dreq_count #(
    parameter int LEN_W   = 16,
    parameter int BURST_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld,
    input  logic [LEN_W-1:0]   ld_val,
    input  logic               dec,
    input  logic [BURST_W-1:0] step,
    output logic [LEN_W-1:0]   rem
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem <= '0;
        end else if (ld) begin
            rem <= ld_val;
        end else if (dec) begin
            rem <= rem - LEN_W'(step);
        end
    end

endmodule

// File: rtl/dreq_flowgen.sv
module dreq_flowgen
    import dreq_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int BURST_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [LEN_W-1:0]   pkt_len,
    input  logic [BURST_W-1:0] burst_sz,
    input  logic [LEN_W-1:0]   ready_cnt,
    input  logic               dma_clr,
    output logic               req_burst,
    output logic               req_last_burst,
    output logic               req_single,
    output logic               req_last_single,
    output logic               pkt_done
);

    localparam logic [BURST_W-1:0] ONE_ITEM = BURST_W'(1);

    dreq_state_e        state, state_nx;
    dreq_kind_e         kind;
    logic [LEN_W-1:0]   rem;
    logic [BURST_W-1:0] bsz_q;
    logic [BURST_W-1:0] step;
    logic               accept;
    logic               in_req;
    logic               is_last;
    logic               serviced;

    assign accept   = load && (state == ST_IDLE);
    assign in_req   = (state == ST_BURST) || (state == ST_LBURST) ||
                      (state == ST_SINGLE) || (state == ST_LSINGLE);
    assign is_last  = (state == ST_LBURST) || (state == ST_LSINGLE);
    assign serviced = dma_clr && in_req;
    assign step     = ((state == ST_BURST) || (state == ST_LBURST)) ? bsz_q : ONE_ITEM;

    dreq_select #(.LEN_W(LEN_W), .BURST_W(BURST_W)) u_sel (
        .rem   (rem),
        .bsz   (bsz_q),
        .ready (ready_cnt),
        .kind  (kind)
    );

    dreq_count #(.LEN_W(LEN_W), .BURST_W(BURST_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (accept),
        .ld_val (pkt_len),
        .dec    (serviced),
        .step   (step),
        .rem    (rem)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Packet parameters and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bsz_q    <= ONE_ITEM;
            pkt_done <= 1'b0;
        end else begin
            if (accept) begin
                bsz_q <= (burst_sz == '0) ? ONE_ITEM : burst_sz;
            end
            pkt_done <= serviced && is_last;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept && (pkt_len != '0)) state_nx = ST_EVAL;
            end
            ST_EVAL: begin
                unique case (kind)
                    K_BURST:   state_nx = ST_BURST;
                    K_LBURST:  state_nx = ST_LBURST;
                    K_SINGLE:  state_nx = ST_SINGLE;
                    K_LSINGLE: state_nx = ST_LSINGLE;
                    default:   state_nx = ST_EVAL;
                endcase
            end
            ST_BURST, ST_SINGLE: begin
                if (dma_clr) state_nx = ST_EVAL;
            end
            ST_LBURST, ST_LSINGLE: begin
                if (dma_clr) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Request outputs
    always_comb begin
        req_burst       = 1'b0;
        req_last_burst  = 1'b0;
        req_single      = 1'b0;
        req_last_single = 1'b0;
        unique case (state)
            ST_BURST:   req_burst       = 1'b1;
            ST_LBURST:  req_last_burst  = 1'b1;
            ST_SINGLE:  req_single      = 1'b1;
            ST_LSINGLE: req_last_single = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/dreq_checker.sv
module dreq_checker (
    input logic clk,
    input logic rst_n,
    input logic dma_clr,
    input logic req_burst,
    input logic req_last_burst,
    input logic req_single,
    input logic req_last_single,
    input logic pkt_done
);

    logic [3:0] reqs;
    logic       any_req;

    assign reqs    = {req_burst, req_last_burst, req_single, req_last_single};
    assign any_req = |reqs;

    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reqs));

    a_r5_hold_until_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && !dma_clr) |=> $stable(reqs));

    a_r6_gap_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && dma_clr) |=> !any_req);

    a_r7_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> $past(dma_clr && (req_last_burst || req_last_single)));

    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> !any_req);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

endmodule

bind dreq_flowgen dreq_checker u_chk (.*);

// File: tb/tb_dreq_flowgen.sv
module tb_dreq_flowgen;

    localparam int LEN_W   = 16;
    localparam int BURST_W = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               load = 1'b0;
    logic [LEN_W-1:0]   pkt_len = '0;
    logic [BURST_W-1:0] burst_sz = '0;
    logic [LEN_W-1:0]   ready_cnt = '0;
    logic               dma_clr = 1'b0;
    logic req_burst, req_last_burst, req_single, req_last_single, pkt_done;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    dreq_flowgen #(.LEN_W(LEN_W), .BURST_W(BURST_W)) dut (
        .clk(clk), .rst_n(rst_n), .load(load), .pkt_len(pkt_len),
        .burst_sz(burst_sz), .ready_cnt(ready_cnt), .dma_clr(dma_clr),
        .req_burst(req_burst), .req_last_burst(req_last_burst),
        .req_single(req_single), .req_last_single(req_last_single),
        .pkt_done(pkt_done)
    );

    // kind codes: 0 none, 1 burst, 2 last burst, 3 single, 4 last single, 9 illegal
    function automatic int exp_kind(int rem, int bsz, int av);
        if (rem == 0) return 0;
        if (rem == 1) return (av >= 1) ? 4 : 0;
        if (rem < bsz) return (av >= 1) ? 3 : 0;
        if (rem == bsz) return (av >= bsz) ? 2 : 0;
        return (av >= bsz) ? 1 : 0;
    endfunction

    function automatic int got_kind();
        case ({req_burst, req_last_burst, req_single, req_last_single})
            4'b0000: return 0;
            4'b1000: return 1;
            4'b0100: return 2;
            4'b0010: return 3;
            4'b0001: return 4;
            default: return 9;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_packet(input int len, input int bsz_in, input bit poke_load);
        int rem;
        int bsz;
        int guard;
        int av;
        int exp;
        int got;
        rem = len;
        bsz = (bsz_in == 0) ? 1 : bsz_in;
        load = 1'b1; pkt_len = LEN_W'(len); burst_sz = BURST_W'(bsz_in);
        @(negedge clk);
        load = 1'b0;
        guard = 0;
        while (rem > 0 && guard < 400) begin
            guard++;
            av = ($urandom % 4 == 0) ? int'($urandom % 3) : int'($urandom % (rem + 4));
            ready_cnt = LEN_W'(av);
            if (poke_load && guard == 2) begin
                load = 1'b1; pkt_len = LEN_W'(3); burst_sz = BURST_W'(1);
                @(negedge clk);
                load = 1'b0;
            end
            repeat (3) @(negedge clk);
            exp = exp_kind(rem, bsz, av);
            got = got_kind();
            check(got != 9, "R1 one-hot", got, exp);
            check(got == exp, (exp == 1) ? "R2 burst" : (exp == 2) ? "R3 last burst" :
                  (exp == 0) ? "R2/R3/R4 no request (R9 load ignored)" : "R4 single kind", got, exp);
            if (got == exp && exp != 0) begin
                if ($urandom % 2 == 0) begin
                    ready_cnt = LEN_W'(rem + 20);
                    repeat (2) @(negedge clk);
                    check(got_kind() == exp, "R5 held, no promotion", got_kind(), exp);
                end
                dma_clr = 1'b1;
                @(negedge clk);
                dma_clr = 1'b0;
                check(got_kind() == 0, "R6 gap after clear", got_kind(), 0);
                check(pkt_done == (exp == 2 || exp == 4), "R7 done pulse", int'(pkt_done),
                      int'(exp == 2 || exp == 4));
                rem = rem - ((exp == 1 || exp == 2) ? bsz : 1);
            end
        end
        check(rem == 0, "R6 packet drained", rem, 0);
        ready_cnt = LEN_W'(100);
        @(negedge clk);
        check(pkt_done == 1'b0, "R7 done one cycle", int'(pkt_done), 0);
        repeat (3) @(negedge clk);
        check(got_kind() == 0, "R7 quiet after last", got_kind(), 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(got_kind() == 0 && !pkt_done, "R10 reset state", got_kind(), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(got_kind() == 0 && !pkt_done, "R10 after reset release", got_kind(), 0);

        // R8 zero length
        load = 1'b1; pkt_len = '0; burst_sz = BURST_W'(4); ready_cnt = LEN_W'(50);
        @(negedge clk);
        load = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check(got_kind() == 0 && !pkt_done, "R8 zero length", got_kind(), 0);
        end

        // R8 length one: expect last single directly
        load = 1'b1; pkt_len = LEN_W'(1); burst_sz = BURST_W'(4); ready_cnt = LEN_W'(5);
        @(negedge clk);
        load = 1'b0;
        repeat (2) @(negedge clk);
        check(got_kind() == 4, "R8 length one", got_kind(), 4);
        dma_clr = 1'b1;
        @(negedge clk);
        dma_clr = 1'b0;
        check(pkt_done == 1'b1, "R7 done after last single", int'(pkt_done), 1);
        repeat (3) @(negedge clk);

        run_packet(8, 4, 1'b0);   // exact multiple: bursts then last burst
        run_packet(7, 4, 1'b0);   // remainder: burst, singles, last single
        run_packet(3, 0, 1'b0);   // R9 zero burst size treated as one
        run_packet(1, 1, 1'b0);   // R4 size one: last single only
        run_packet(20, 5, 1'b1);  // R9 load during packet ignored
        for (int i = 0; i < 25; i++) begin
            run_packet(int'($urandom % 31), int'($urandom % 9), 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule